// File: doc/BRIEF.md
# Cell-Level ATM Transmit Slave Port

This block is the slave end of a 16-bit transmit link from an ATM master. It runs with a single PHY and moves whole cells. The master presents one word per cycle on the data bus, qualified by an active-low enable, and marks the first word of each cell with a one-cycle start-of-cell flag. The cell length in bytes comes from a static configuration input, so a cell is `cell_bytes/2` words long. Optional odd parity is checked on every accepted word.

Words go straight into a downstream cell buffer as an uncommitted write stream. When the last word of a cell arrives, the port commits the cell if no parity error was seen in it. Otherwise it rolls the cell back and raises a one-cycle error pulse with a two-bit cause. If a start-of-cell arrives before the current cell is complete, the partial cell is rolled back with a length cause, and that word begins a new cell.

The write stream has no per-word ready signal. Back-pressure reaches the master only through the cell-available output. That output is high only when the buffer's free word count covers the rest of the current cell plus one more full cell, so every word the master is allowed to send has room waiting for it.

Top module: `utx_cell_slave`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `wr_valid`, `wr_commit`, `wr_abort` and `err_pulse` are 0 and `err_cause` is 2'b00.
- R2: A word is accepted only in a cycle where `tx_enb_n` is sampled low. An accepted word that belongs to a cell appears on `wr_data` with `wr_valid` high in the next cycle. Cycles with `tx_enb_n` high pause a cell without ending it.
- R3: A cell begins at an accepted word with `tx_soc` high. Accepted words with `tx_soc` low that arrive outside a cell are ignored and produce no write.
- R4: A cell holds `cell_bytes[7:1]` words (`cell_bytes` is even, 16..128). If no parity error was seen in the cell, `wr_commit` is high in the same cycle as the write of its last word.
- R5: A start-of-cell in the cycle right after the last word of a cell is accepted with no idle cycle, and both cells are committed.
- R6: When `par_en` is 1, a word whose 16 data bits plus `tx_par` hold an even number of ones is a parity error. A cell that contains one is rolled back: `wr_abort` and `err_pulse` are high with `err_cause` = 2'b01 exactly one cycle after its last word is written.
- R7: When `par_en` is 0, parity is ignored, `err_cause[0]` never becomes 1, and a cell with bad parity is committed.
- R8: An accepted `tx_soc` inside an incomplete cell is a length error. In the cycle that word is written, `wr_abort` and `err_pulse` are high with `err_cause[1]` = 1 and `err_cause[0]` = 1 if a parity error was seen in the truncated words. That word starts a new cell.
- R9: In a cycle with `wr_valid`, `wr_abort` discards only the words written in earlier cycles, and `wr_commit` includes the word written in that cycle.
- R10: `tx_cav` is registered. It is 1 when `buf_free` is at least the words still missing from the current cell (0 outside a cell) plus one full cell, and 0 otherwise.
- R11: `err_pulse` is high only together with `wr_abort`, and `wr_commit` and `wr_abort` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 16 | Word from the master |
| tx_par | input | 1 | Parity bit covering `tx_data` |
| tx_soc | input | 1 | First word of a cell |
| tx_enb_n | input | 1 | Active-low word enable |
| tx_cav | output | 1 | Cell available: room for the rest of this cell and one more |
| par_en | input | 1 | Static: enable odd-parity checking |
| cell_bytes | input | 8 | Static: cell length in bytes, bit 0 zero |
| buf_free | input | 10 | Free words in the downstream buffer |
| wr_valid | output | 1 | Uncommitted word write to the buffer |
| wr_data | output | 16 | Word being written |
| wr_commit | output | 1 | Make the open cell (including this cycle's word) visible |
| wr_abort | output | 1 | Discard the open words written before this cycle |
| err_pulse | output | 1 | One-cycle cell-discard indication |
| err_cause | output | 2 | Bit 0 parity error, bit 1 length error; valid with `err_pulse` |

## Verification
The bench aims at the moments where a cell boundary meets something else. A cell ending with bad parity followed at once by a good cell tests the ordering of the delayed rollback: a design that applies the abort after the write would lose the first word of the next cell. A premature start-of-cell tests that the truncated words are dropped and the new word is kept; a design that counted the new word into the old cell would commit a misaligned cell. Stray words with no start-of-cell, a paused cell, a cell size change and static free-space levels around the threshold show up as wrong lengths, extra commits or a wrong available flag.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic {
    CELL_IDLE = 1'b0,
    CELL_BODY = 1'b1
  } cell_state_t;

  localparam int unsigned CAUSE_W   = 2;
  localparam int unsigned CAUSE_PAR = 0;
  localparam int unsigned CAUSE_LEN = 1;
endpackage

// File: rtl/utx_parity_chk.sv
module utx_parity_chk #(
  parameter int unsigned DATA_W = 16,
  parameter bit          ODD    = 1'b1
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  input  logic              en,
  output logic              bad
);
  logic ones_odd;
  assign ones_odd = ^{data, par};

  generate
    if (ODD) begin : g_odd
      assign bad = en && !ones_odd;
    end else begin : g_even
      assign bad = en && ones_odd;
    end
  endgenerate
endmodule

// File: rtl/utx_cell_track.sv
module utx_cell_track
  import utx_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             soc,
  input  logic             bad_word,
  input  logic [CNT_W-1:0] wpc,
  output logic             ev_write,
  output logic             ev_len_err,
  output logic             ev_last_ok,
  output logic             ev_last_bad,
  output logic             len_par,
  output logic             in_cell,
  output logic [CNT_W-1:0] cnt
);
  cell_state_t      st;
  logic             par_seen;
  logic [CNT_W-1:0] nxt;
  logic             at_end;

  always_comb begin
    nxt         = cnt + 1'b1;
    in_cell     = (st == CELL_BODY);
    ev_write    = acc && (soc || in_cell);
    ev_len_err  = acc && soc && in_cell;
    len_par     = par_seen;
    at_end      = acc && !soc && in_cell && (nxt == wpc);
    ev_last_ok  = at_end && !(par_seen || bad_word);
    ev_last_bad = at_end && (par_seen || bad_word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CELL_IDLE;
      cnt      <= '0;
      par_seen <= 1'b0;
    end else if (acc) begin
      if (soc) begin
        st       <= CELL_BODY;
        cnt      <= {{(CNT_W-1){1'b0}}, 1'b1};
        par_seen <= bad_word;
      end else if (st == CELL_BODY) begin
        if (nxt == wpc) begin
          st       <= CELL_IDLE;
          cnt      <= '0;
          par_seen <= 1'b0;
        end else begin
          cnt      <= nxt;
          par_seen <= par_seen || bad_word;
        end
      end
    end
  end

  // count never reaches the cell length while a cell is open
  assert_cnt_below_len_R4: assert property (@(posedge clk) disable iff (rst)
    (st == CELL_BODY) |-> (cnt < wpc));
  // the count restarts at one on every start word
  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && soc) |=> (st == CELL_BODY && cnt == 1));
endmodule

// File: rtl/utx_wr_stage.sv
module utx_wr_stage
  import utx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_write,
  input  logic [DATA_W-1:0]  data,
  input  logic               ev_last_ok,
  input  logic               ev_last_bad,
  input  logic               ev_len_err,
  input  logic               len_par,
  output logic               wr_valid,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_commit,
  output logic               wr_abort,
  output logic               err_pulse,
  output logic [CAUSE_W-1:0] err_cause
);
  logic               pend_drop;
  logic [CAUSE_W-1:0] cause_d;

  always_comb begin
    cause_d = '0;
    if (ev_len_err) begin
      cause_d[CAUSE_LEN] = 1'b1;
      cause_d[CAUSE_PAR] = len_par;
    end else if (pend_drop) begin
      cause_d[CAUSE_PAR] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
      wr_abort  <= 1'b0;
      err_pulse <= 1'b0;
      err_cause <= '0;
      pend_drop <= 1'b0;
    end else begin
      wr_valid  <= ev_write;
      if (ev_write) wr_data <= data;
      wr_commit <= ev_last_ok;
      pend_drop <= ev_last_bad;
      wr_abort  <= ev_len_err || pend_drop;
      err_pulse <= ev_len_err || pend_drop;
      err_cause <= cause_d;
    end
  end

  assert_commit_abort_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(wr_commit && wr_abort));
  // a cell ending with bad parity is dropped one cycle after its last write
  assert_parity_drop_R6: assert property (@(posedge clk) disable iff (rst)
    ev_last_bad |=> ##1 (wr_abort && err_cause == 2'b01));
endmodule

// File: rtl/utx_cav_gen.sv
module utx_cav_gen #(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned FREE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_cell,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  wpc,
  input  logic [FREE_W-1:0] buf_free,
  output logic              cav
);
  localparam int unsigned SUM_W = (FREE_W > CNT_W ? FREE_W : CNT_W) + 2;

  logic [SUM_W-1:0] missing;
  logic [SUM_W-1:0] need;

  always_comb begin
    missing = in_cell ? (SUM_W'(wpc) - SUM_W'(cnt)) : '0;
    need    = missing + SUM_W'(wpc);
  end

  always_ff @(posedge clk) begin
    if (rst) cav <= 1'b0;
    else     cav <= (SUM_W'(buf_free) >= need);
  end
endmodule

// File: rtl/utx_cell_slave.sv
module utx_cell_slave
  import utx_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned FREE_W  = 10,
  parameter bit          ODD_PAR = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               tx_par,
  input  logic               tx_soc,
  input  logic               tx_enb_n,
  output logic               tx_cav,
  input  logic               par_en,
  input  logic [CFG_W-1:0]   cell_bytes,
  input  logic [FREE_W-1:0]  buf_free,
  output logic               wr_valid,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_commit,
  output logic               wr_abort,
  output logic               err_pulse,
  output logic [CAUSE_W-1:0] err_cause
);
  localparam int unsigned CNT_W = CFG_W - 1;

  logic             acc;
  logic             bad_word;
  logic [CNT_W-1:0] wpc;
  logic             ev_write, ev_len_err, ev_last_ok, ev_last_bad, len_par;
  logic             in_cell;
  logic [CNT_W-1:0] cnt;

  assign acc = !tx_enb_n;
  assign wpc = cell_bytes[CFG_W-1:1];

  utx_parity_chk #(.DATA_W(DATA_W), .ODD(ODD_PAR)) u_par (
    .data(tx_data), .par(tx_par), .en(par_en), .bad(bad_word)
  );

  utx_cell_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .acc(acc), .soc(tx_soc), .bad_word(bad_word),
    .wpc(wpc), .ev_write(ev_write), .ev_len_err(ev_len_err),
    .ev_last_ok(ev_last_ok), .ev_last_bad(ev_last_bad), .len_par(len_par),
    .in_cell(in_cell), .cnt(cnt)
  );

  utx_wr_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst), .ev_write(ev_write), .data(tx_data),
    .ev_last_ok(ev_last_ok), .ev_last_bad(ev_last_bad),
    .ev_len_err(ev_len_err), .len_par(len_par),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_commit(wr_commit),
    .wr_abort(wr_abort), .err_pulse(err_pulse), .err_cause(err_cause)
  );

  utx_cav_gen #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_cav (
    .clk(clk), .rst(rst), .in_cell(in_cell), .cnt(cnt), .wpc(wpc),
    .buf_free(buf_free), .cav(tx_cav)
  );

  assert_ignore_stray_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && !tx_soc && !in_cell) |=> !wr_valid);
  assert_start_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && tx_soc) |=> (wr_valid && wr_data == $past(tx_data)));
  assert_early_soc_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && tx_soc && in_cell) |=> (err_pulse && err_cause[CAUSE_LEN] && wr_valid));
  assert_commit_with_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> wr_valid);
  // parity enable is a static strap; the window covers the two-stage drop path
  assert_no_parity_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (!par_en && $past(!par_en) && $past(!par_en, 2)) |-> !err_cause[CAUSE_PAR]);
endmodule

// File: tb/utx_cell_slave_bench.sv
module utx_cell_slave_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tx_data = '0;
  logic        tx_par = 1'b0, tx_soc = 1'b0, tx_enb_n = 1'b1;
  logic        tx_cav;
  logic        par_en = 1'b1;
  logic [7:0]  cell_bytes = 8'd16;
  logic [9:0]  buf_free = 10'd1000;
  logic        wr_valid, wr_commit, wr_abort, err_pulse;
  logic [15:0] wr_data;
  logic [1:0]  err_cause;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0] exp_words[$];
  int          exp_len[$];
  logic [1:0]  exp_err[$];
  logic [15:0] open_words[$];

  always #2.5 clk = ~clk;

  utx_cell_slave u_utx_cell_slave (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_par(tx_par), .tx_soc(tx_soc),
    .tx_enb_n(tx_enb_n), .tx_cav(tx_cav), .par_en(par_en),
    .cell_bytes(cell_bytes), .buf_free(buf_free), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_commit(wr_commit), .wr_abort(wr_abort),
    .err_pulse(err_pulse), .err_cause(err_cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [15:0] d, input bit soc, input bit bad);
    @(negedge clk);
    tx_enb_n = 1'b0;
    tx_data  = d;
    tx_soc   = soc;
    tx_par   = bad ? ^d : ~^d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_enb_n = 1'b1;
      tx_soc   = 1'b0;
    end
  endtask

  // drive n words; bad_idx marks a word with wrong parity (-1 for none);
  // a short cell must be followed by another start word
  task automatic send_cell(input logic [15:0] base, input int n, input int bad_idx,
                           input int pause_at);
    int  wpc;
    bit  perr;
    wpc  = cell_bytes[7:1];
    perr = par_en && (bad_idx >= 0) && (bad_idx < n);
    if (n < wpc) exp_err.push_back({1'b1, perr});
    else if (perr) exp_err.push_back(2'b01);
    else begin
      exp_len.push_back(n);
      for (int i = 0; i < n; i++) exp_words.push_back(base + 16'(i));
    end
    for (int i = 0; i < n; i++) begin
      put_word(base + 16'(i), i == 0, i == bad_idx);
      if (i == pause_at) idle(3);
    end
  endtask

  // scoreboard monitor: abort acts before the write, commit after it (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (err_pulse || wr_abort)
          check(err_pulse == wr_abort, "R11 err/abort together", err_pulse, wr_abort);
        if (wr_commit && wr_abort)
          check(1'b0, "R11 commit with abort", 1, 0);
        if (wr_abort) open_words.delete();
        if (wr_valid) open_words.push_back(wr_data);
        if (wr_commit) begin
          if (exp_len.size() == 0) check(1'b0, "R4 unexpected commit", open_words.size(), 0);
          else begin
            int n;
            bit ok;
            n  = exp_len.pop_front();
            ok = (open_words.size() == n);
            for (int i = 0; i < n; i++) begin
              logic [15:0] e;
              e = exp_words.pop_front();
              if (ok && open_words[i] != e) begin
                ok = 1'b0;
                $display("FAIL R4 word %0d actual=%0h expected=%0h", i, open_words[i], e);
              end
            end
            check(ok, "R4 committed cell", open_words.size(), n);
          end
          open_words.delete();
        end
        if (err_pulse) begin
          if (exp_err.size() == 0) check(1'b0, "R6/R8 unexpected error", err_cause, 0);
          else begin
            logic [1:0] e;
            e = exp_err.pop_front();
            check(err_cause == e, "R6/R8 error cause", err_cause, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!wr_valid && !wr_commit && !wr_abort && !err_pulse && err_cause == 0,
          "R1 reset outputs", {wr_valid, wr_commit, wr_abort, err_pulse}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!wr_valid && !err_pulse, "R1 after reset", {wr_valid, err_pulse}, 0);
    check(tx_cav == 1'b1, "R10 idle with room", tx_cav, 1);

    send_cell(16'h0100, 8, -1, -1);                // R2 R4 plain cell
    idle(2);
    send_cell(16'h0200, 8, -1, 3);                 // R2 paused cell
    idle(2);
    put_word(16'hdead, 0, 0); put_word(16'hbeef, 0, 0);   // R3 stray words
    idle(1);
    send_cell(16'h0300, 8, -1, -1);
    // R5 back-to-back cells
    send_cell(16'h0400, 8, -1, -1);
    send_cell(16'h0500, 8, -1, -1);
    send_cell(16'h0600, 8, -1, -1);
    idle(2);
    // R6 parity error, then R9 a good cell right behind it
    send_cell(16'h0700, 8, 5, -1);
    send_cell(16'h0800, 8, -1, -1);
    idle(2);
    send_cell(16'h0900, 8, 7, -1);                 // R6 error on last word
    idle(3);
    // R7 parity ignored when disabled
    par_en = 1'b0;
    idle(3);
    send_cell(16'h0a00, 8, 2, -1);
    idle(3);
    par_en = 1'b1;
    idle(3);
    // R8 premature start: with and without parity error in the short part
    send_cell(16'h0b00, 5, -1, -1);
    send_cell(16'h0c00, 8, -1, -1);
    send_cell(16'h0d00, 3, 1, -1);
    send_cell(16'h0e00, 8, -1, -1);
    idle(2);
    // R4 a different cell size
    cell_bytes = 8'd20;
    idle(2);
    send_cell(16'h0f00, 10, -1, -1);
    idle(2);
    cell_bytes = 8'd16;
    // R10 cell-available levels
    buf_free = 10'd7;
    idle(2);
    check(tx_cav == 1'b0, "R10 below one cell", tx_cav, 0);
    buf_free = 10'd8;
    idle(2);
    check(tx_cav == 1'b1, "R10 exactly one cell", tx_cav, 1);
    buf_free = 10'd12;
    exp_len.push_back(8);
    for (int i = 0; i < 8; i++) exp_words.push_back(16'h1000 + 16'(i));
    for (int i = 0; i < 3; i++) put_word(16'h1000 + 16'(i), i == 0, 0);
    idle(2);
    check(tx_cav == 1'b0, "R10 mid-cell short by one", tx_cav, 0);
    buf_free = 10'd13;
    idle(2);
    check(tx_cav == 1'b1, "R10 mid-cell enough", tx_cav, 1);
    for (int i = 3; i < 8; i++) put_word(16'h1000 + 16'(i), 0, 0);
    idle(5);
    buf_free = 10'd1000;
    check(exp_len.size() == 0, "R4 all cells committed", exp_len.size(), 0);
    check(exp_err.size() == 0, "R8 all errors seen", exp_err.size(), 0);
    check(open_words.size() == 0, "R3 no stray writes", open_words.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule